// File: doc/BRIEF.md
# Tone Channel Length Timer

This block holds the length timer of one tone channel in a programmable sound generator. Software programs a length through a length register. It then uses a control register to arm the timer and to restart the channel. While the timer is armed, a periodic step strobe from the frame sequencer counts it down. When the count reaches zero, the channel is silenced.

A write to the control register is more than a plain register update. Arming the timer while the sequencer is in the first half of its length period costs one count at once. A count that has reached zero stays frozen until it is reloaded. A restart (trigger) with the count at zero reloads the full length, and in the first half of the period it also takes one extra count. A disabled DAC stops the channel-active flag from being set, but the trigger still acts on the counter.

The maximum length is a parameter (64 or 256). A second parameter picks a variant in which a write that leaves the timer disarmed also costs a count in the first half of the period.

Top module: `snd_len_timer`

## Requirements
- R1: After a synchronous reset the counter reads 0, the timer is disarmed and chanActive is 0.
- R2: A write with wrAddr=0 loads the counter with MAX_LEN minus the low log2(MAX_LEN) bits of wrData. A field value of 0 loads MAX_LEN. The write does not change chanActive.
- R3: While the timer is armed and the count is nonzero, a stepStrobe lowers the count by one. While the timer is disarmed, a strobe does nothing. A strobe in the same cycle as any register write is dropped.
- R4: A control write (wrAddr=1) whose bit 6 arms a disarmed timer takes one extra count when firstHalf=1. The same write with firstHalf=0 takes none.
- R5: A control write that keeps the timer armed takes no extra count, and neither does one that disarms it. A write that keeps it disarmed takes none when ALT_IDLE_CLOCK=0. With ALT_IDLE_CLOCK=1 it takes one extra count when firstHalf=1.
- R6: When any decrement brings the count to zero, chanActive reads 0 after that same clock edge.
- R7: A count of zero is frozen: strobes and arming writes leave it at 0 and never wrap it.
- R8: A control write with bit 7 (trigger) set, where the count is zero after any extra count of the same write, reloads MAX_LEN. If bit 6 is set and firstHalf=1, it reloads MAX_LEN-1 instead. A count of 1 with data 0xC0 in the first half therefore ends at MAX_LEN-1.
- R9: A trigger with a nonzero count leaves the count unchanged.
- R10: A trigger with dacOn=1 sets chanActive. With dacOn=0, chanActive clears on the next edge and cannot be set, while the trigger's counter effects still take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects the length register, 1 selects the control register |
| wrData | input | 8 | Write data; control bit 6 arms the timer, bit 7 triggers |
| stepStrobe | input | 1 | Length step pulse from the frame sequencer |
| firstHalf | input | 1 | 1 while the sequencer is in the first half of the length period |
| dacOn | input | 1 | DAC enable; gates chanActive |
| chanActive | output | 1 | Channel is active |
| lenValue | output | log2(MAX_LEN)+1 | Current counter value |

## Verification
Arming writes are driven in both halves of the length period and from each previous arm state. This separates the extra-count rule from the ordinary strobe count, and the base variant from the alternate one. Triggers are applied with the count at zero, at one and well above one, in both halves. These cases tell the plain reload apart from the reload with an extra count, and from the double count of a single write that both arms and triggers. The same trigger patterns are repeated with the DAC off. This shows that the counter effects do not depend on the DAC while the active flag does.

// File: rtl/snd_len_pkg.sv
package snd_len_pkg;

  // Register select values on wrAddr
  localparam logic ADDR_LEN = 1'b0;
  localparam logic ADDR_CTL = 1'b1;

  // Control byte bit positions
  localparam int ARM_BIT  = 6;
  localparam int TRIG_BIT = 7;

  // Strobes from the control decoder to the counter datapath
  typedef struct packed {
    logic lenWr;      // load the counter from the length byte
    logic ctrlWr;     // control write this cycle
    logic newArm;     // arm bit carried by the control write
    logic trig;       // trigger bit of the control write
    logic extraDec;   // control write takes an immediate extra count
    logic reloadDec;  // a reload from zero also takes one count
    logic stepDec;    // sequencer strobe may count down this cycle
  } lenStrobes_t;

endpackage

// File: rtl/snd_len_ctrl.sv
module snd_len_ctrl
  import snd_len_pkg::*;
#(
  parameter bit ALT_IDLE_CLOCK = 1'b0
) (
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [7:0]  wrData,
  input  logic        stepStrobe,
  input  logic        firstHalf,
  input  logic        armQ,
  output lenStrobes_t strb
);

  logic ctrlHit;
  logic newArm;
  logic idleExtra;

  assign ctrlHit = wrEn && (wrAddr == ADDR_CTL);
  assign newArm  = wrData[ARM_BIT];

  // The variant decides whether a write that stays disarmed costs a count
  generate
    if (ALT_IDLE_CLOCK) begin : g_idleClk
      assign idleExtra = !newArm;
    end else begin : g_idleNone
      assign idleExtra = 1'b0;
    end
  endgenerate

  always_comb begin
    strb           = '0;
    strb.lenWr     = wrEn && (wrAddr == ADDR_LEN);
    strb.ctrlWr    = ctrlHit;
    strb.newArm    = newArm;
    strb.trig      = ctrlHit && wrData[TRIG_BIT];
    // only a write from the disarmed state can take the extra count
    strb.extraDec  = ctrlHit && firstHalf && !armQ && (newArm || idleExtra);
    strb.reloadDec = newArm && firstHalf;
    // register writes take precedence over the sequencer strobe
    strb.stepDec   = stepStrobe && !wrEn && armQ;
  end

endmodule

// File: rtl/snd_len_dp.sv
module snd_len_dp
  import snd_len_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LOAD_W  = $clog2(MAX_LEN),
  parameter int CNT_W   = LOAD_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  lenStrobes_t      strb,
  input  logic [7:0]       wrData,
  input  logic             dacOn,
  output logic             armQ,
  output logic             activeQ,
  output logic [CNT_W-1:0] cntQ
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cntAfterExtra;
  logic [CNT_W-1:0] cntNext;
  logic             armNext;
  logic             activeNext;
  logic             extraHit;

  // the length byte is written as (maximum - length)
  assign loadVal = MAX_V - CNT_W'(wrData[LOAD_W-1:0]);

  // first stage: the extra count of a control write, which respects the freeze
  assign extraHit      = strb.extraDec && (cntQ != '0);
  assign cntAfterExtra = extraHit ? (cntQ - ONE_V) : cntQ;

  always_comb begin
    cntNext    = cntQ;
    armNext    = armQ;
    activeNext = activeQ;
    if (strb.lenWr) begin
      cntNext = loadVal;
    end else if (strb.ctrlWr) begin
      armNext = strb.newArm;
      cntNext = cntAfterExtra;
      if (extraHit && (cntAfterExtra == '0)) begin
        activeNext = 1'b0;
      end
      // second stage: a trigger unfreezes a zero count
      if (strb.trig) begin
        if (cntAfterExtra == '0) begin
          cntNext = strb.reloadDec ? (MAX_V - ONE_V) : MAX_V;
        end
        if (dacOn) begin
          activeNext = 1'b1;
        end
      end
    end else if (strb.stepDec && (cntQ != '0)) begin
      cntNext = cntQ - ONE_V;
      if (cntQ == ONE_V) begin
        activeNext = 1'b0;
      end
    end
    if (!dacOn) begin
      activeNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ    <= '0;
      armQ    <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      cntQ    <= cntNext;
      armQ    <= armNext;
      activeQ <= activeNext;
    end
  end

endmodule

// File: rtl/snd_len_timer.sv
module snd_len_timer
  import snd_len_pkg::*;
#(
  parameter int MAX_LEN        = 64,
  parameter bit ALT_IDLE_CLOCK = 1'b0,
  parameter int LOAD_W         = $clog2(MAX_LEN),
  parameter int CNT_W          = LOAD_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [7:0]       wrData,
  input  logic             stepStrobe,
  input  logic             firstHalf,
  input  logic             dacOn,
  output logic             chanActive,
  output logic [CNT_W-1:0] lenValue
);

  lenStrobes_t strb;
  logic        lenArmQ;
  logic        activeQ;

  snd_len_ctrl #(
    .ALT_IDLE_CLOCK(ALT_IDLE_CLOCK)
  ) ctrl_i (
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .stepStrobe(stepStrobe),
    .firstHalf (firstHalf),
    .armQ      (lenArmQ),
    .strb      (strb)
  );

  snd_len_dp #(
    .MAX_LEN(MAX_LEN),
    .LOAD_W (LOAD_W),
    .CNT_W  (CNT_W)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .wrData (wrData),
    .dacOn  (dacOn),
    .armQ   (lenArmQ),
    .activeQ(activeQ),
    .cntQ   (lenValue)
  );

  assign chanActive = activeQ;

endmodule

// File: rtl/snd_len_chk.sv
module snd_len_chk #(
  parameter int MAX_LEN = 64,
  parameter int CNT_W   = $clog2(MAX_LEN) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             stepStrobe,
  input logic             dacOn,
  input logic             lenArmQ,
  input logic             chanActive,
  input logic [CNT_W-1:0] lenValue
);

  // R2: the counter never exceeds the maximum length
  a_r2_bounded: assert property (@(posedge clk) disable iff (rst)
    lenValue <= CNT_W'(MAX_LEN));

  // R3: an armed strobe with no write lowers a count above one by one
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && stepStrobe && lenArmQ && lenValue > CNT_W'(1))
      |=> lenValue == $past(lenValue) - CNT_W'(1));

  // R3: with neither a write nor a strobe the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !stepStrobe) |=> $stable(lenValue));

  // R6: a strobe from one reaches zero and silences the channel
  a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && stepStrobe && lenArmQ && lenValue == CNT_W'(1))
      |=> (lenValue == '0) && !chanActive);

  // R7: without a write a zero count stays zero
  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && lenValue == '0) |=> lenValue == '0);

  // R10: a disabled DAC forces the channel inactive
  a_r10_dac_gate: assert property (@(posedge clk) disable iff (rst)
    !dacOn |=> !chanActive);

endmodule

bind snd_len_timer snd_len_chk #(
  .MAX_LEN(MAX_LEN),
  .CNT_W  (CNT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .stepStrobe(stepStrobe),
  .dacOn     (dacOn),
  .lenArmQ   (lenArmQ),
  .chanActive(chanActive),
  .lenValue  (lenValue)
);

// File: tb/snd_len_timer_tb_top.sv
module snd_len_timer_tb_top;

  localparam int MAXL = 64;
  localparam int CW   = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic          wrAddr = 1'b0;
  logic [7:0]    wrData = 8'h00;
  logic          stepStrobe = 1'b0;
  logic          firstHalf = 1'b1;
  logic          dacOn = 1'b1;
  logic          actM, actA;
  logic [CW-1:0] cntM, cntA;

  snd_len_timer #(.MAX_LEN(MAXL), .ALT_IDLE_CLOCK(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stepStrobe(stepStrobe), .firstHalf(firstHalf), .dacOn(dacOn),
    .chanActive(actM), .lenValue(cntM));

  snd_len_timer #(.MAX_LEN(MAXL), .ALT_IDLE_CLOCK(1'b1)) dutAlt_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stepStrobe(stepStrobe), .firstHalf(firstHalf), .dacOn(dacOn),
    .chanActive(actA), .lenValue(cntA));

  typedef struct {
    bit    alt;
    int    cnt;
    bit    act;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int   nCmp = 0;
  int   nBad = 0;
  bit   ended = 0;

  // monitor: compares every queued expectation away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      exp_t e;
      int   gotC;
      bit   gotA;
      e    = expQ.pop_front();
      gotC = e.alt ? int'(cntA) : int'(cntM);
      gotA = e.alt ? actA : actM;
      nCmp++;
      if (gotC != e.cnt || gotA != e.act) begin
        nBad++;
        $display("FAIL %s (%s): count=%0d active=%0d expected count=%0d active=%0d",
                 e.tag, e.alt ? "alt" : "base", gotC, gotA, e.cnt, e.act);
      end
    end
  end

  task automatic expect_v(input bit alt, input int c, input bit a, input string t);
    exp_t e;
    e.alt = alt; e.cnt = c; e.act = a; e.tag = t;
    expQ.push_back(e);
  endtask

  // driver: one cycle of stimulus, then the expected result is queued
  task automatic cyc(input bit we, input bit adr, input logic [7:0] d, input bit stp);
    @(negedge clk);
    #1;
    wrEn = we; wrAddr = adr; wrData = d; stepStrobe = stp;
    @(posedge clk);
    #1;
    wrEn = 1'b0; stepStrobe = 1'b0;
  endtask

  task automatic wrLen(input logic [7:0] d, input int c, input bit a, input string t);
    cyc(1'b1, 1'b0, d, 1'b0);
    expect_v(1'b0, c, a, t);
  endtask

  task automatic wrCtl(input logic [7:0] d, input int c, input bit a, input string t);
    cyc(1'b1, 1'b1, d, 1'b0);
    expect_v(1'b0, c, a, t);
  endtask

  task automatic step(input int c, input bit a, input string t);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    expect_v(1'b0, c, a, t);
  endtask

  task automatic idle(input int c, input bit a, input string t);
    cyc(1'b0, 1'b0, 8'h00, 1'b0);
    expect_v(1'b0, c, a, t);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    expect_v(1'b0, 0, 1'b0, "R1 reset");
    expect_v(1'b1, 0, 1'b0, "R1 reset");
  endtask

  initial begin : watchdog
    #(20 * 200000);
    if (!ended) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin : stimulus
    doReset();

    // R2 length load and R9/R10 trigger with a nonzero count
    wrLen(8'h00, 64, 0, "R2 zero loads max");
    wrCtl(8'h80, 64, 1, "R9 trigger keeps nonzero count");
    wrLen(8'd62, 2, 1, "R2 load 62 gives 2");
    wrLen(8'd127, 1, 1, "R2 upper bits ignored");

    // R3 strobes, R4 second half, R6 zero clears, R7 freeze
    step(1, 1, "R3 disarmed strobe ignored");
    firstHalf = 1'b0;
    wrCtl(8'h40, 1, 1, "R4 arm in second half no extra");
    step(0, 0, "R3 R6 strobe to zero clears active");
    step(0, 0, "R7 strobe at zero frozen");
    wrCtl(8'h00, 0, 0, "R7 disarm at zero");
    firstHalf = 1'b1;
    wrCtl(8'h40, 0, 0, "R7 arm at zero no wrap");

    // R4/R5 extra-count rules in the first half
    wrCtl(8'h00, 0, 0, "R5 disarm");
    wrLen(8'd62, 2, 0, "R2 reload 2");
    wrCtl(8'h80, 2, 1, "R5 R9 disarmed trigger no extra");
    wrCtl(8'h40, 1, 1, "R4 arm in first half extra count");
    wrCtl(8'h40, 1, 1, "R5 armed to armed no extra");
    wrCtl(8'h00, 1, 1, "R5 armed to disarmed no extra");
    wrCtl(8'h00, 1, 1, "R5 disarmed to disarmed no extra");
    step(1, 1, "R3 disarmed strobe ignored");
    wrCtl(8'h40, 0, 0, "R4 R6 extra count to zero clears");

    // R8 reload from zero
    wrCtl(8'hC0, 63, 1, "R8 trigger from zero first half armed");
    wrCtl(8'h00, 63, 1, "R5 disarm no extra");
    wrLen(8'd63, 1, 1, "R2 load 1");
    wrCtl(8'hC0, 63, 1, "R8 arm and trigger from one");
    step(62, 1, "R3 armed strobe counts");
    wrLen(8'd63, 1, 1, "R2 load 1");
    firstHalf = 1'b0;
    wrCtl(8'h00, 1, 1, "R5 disarm");
    wrCtl(8'hC0, 1, 1, "R9 second half trigger at one");
    step(0, 0, "R6 strobe to zero");
    wrCtl(8'hC0, 64, 1, "R8 second half reload max");

    // R10 DAC gating
    dacOn = 1'b0;
    idle(64, 0, "R10 dac off clears active");
    wrCtl(8'h00, 64, 0, "R10 disarm");
    wrLen(8'd63, 1, 0, "R2 load 1");
    firstHalf = 1'b1;
    wrCtl(8'hC0, 63, 0, "R10 counter effects with dac off");
    dacOn = 1'b1;
    wrCtl(8'h80, 63, 1, "R10 trigger sets active");

    // R3 write wins over a coincident strobe
    wrCtl(8'h40, 62, 1, "R4 arm first half");
    cyc(1'b1, 1'b1, 8'h40, 1'b1);
    expect_v(1'b0, 62, 1, "R3 strobe dropped during write");
    step(61, 1, "R3 armed strobe counts");

    // R5 alternate variant
    doReset();
    cyc(1'b1, 1'b0, 8'd62, 1'b0);
    expect_v(1'b0, 2, 0, "R2 load 2");
    expect_v(1'b1, 2, 0, "R2 load 2");
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    expect_v(1'b0, 2, 0, "R5 base idle write no extra");
    expect_v(1'b1, 1, 0, "R5 alt idle write first half extra");
    firstHalf = 1'b0;
    cyc(1'b1, 1'b1, 8'h00, 1'b0);
    expect_v(1'b0, 2, 0, "R5 base idle write second half");
    expect_v(1'b1, 1, 0, "R5 alt idle write second half no extra");

    @(negedge clk);
    @(negedge clk);
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule